// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that gives an external bus master write and read access to a bank of 8-bit configuration registers. The master drives the clock line. The data line is shared, and the slave only ever pulls it low through an output-enable. The slave watches for bus framing conditions and compares the first byte with its own device address. A write transfer carries a register pointer followed by data bytes. A read transfer returns bytes starting at the pointer left behind by earlier traffic.

The device address is fixed at power-up. A mode input and a 3-bit strap field are captured once, just after reset is released. With the mode input low, the slave answers to a single fixed address. With it high, the address is spread across eight values chosen by the strap. Both pins are oversampled by the system clock, which must run at least eight times faster than the bus clock.

Top module: `cfgbus_slave`

## Requirements
- R1: A high-to-low data transition while the clock line is high (START) begins reception of an address byte from any state. A low-to-high data transition while the clock is high (STOP) returns the slave to idle.
- R2: With the mode input low, the first byte after START is matched against 0xC0 for writes and 0xC1 for reads. Bytes go most significant bit first and bit 0 is the direction flag (0 = write, 1 = read). A match is acknowledged by asserting `sda_oe_o` (pulling data low) during the ninth clock.
- R3: With the mode input high, the write address is 0xC0 + 4*strap and the read address is one above it.
- R4: Strap and mode are captured in the first clock after reset release. Later changes on those pins do not change the address the slave answers to.
- R5: On an address mismatch the slave does not acknowledge, drives nothing, and ignores all bytes until the next START. Those bytes leave the registers unchanged.
- R6: In a write transfer the byte after the address sets the register pointer. Each following byte is stored at the pointer. Every one of these bytes is acknowledged.
- R7: The pointer advances by one after every data byte written, wrapping from 0xFF to 0x00.
- R8: A read transfer carries no pointer byte. It returns the register at the current pointer, driven MSB first, and the pointer value persists across transfers.
- R9: The pointer advances after each byte read. A master acknowledge (data low in the ninth clock) continues with the next byte. A not-acknowledge makes the slave release the data line until START or STOP.
- R10: The slave asserts `sda_oe_o` only while the clock line is low.
- R11: A STOP in the middle of a byte leaves the pointer and all registers unchanged.
- R12: After reset `sda_oe_o` is low, every register holds 0x00, and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Address strap, captured after reset |
| multi_id_i | input | 1 | 1 selects strap-based address, 0 the fixed one |

## Verification
A corrupted pointer does not show at once. It only appears in the first data byte of a later read transfer, which may be several transfers after the fault. For that reason the stimulus always reads back through a separate transfer. A wrong protocol state shows up within one byte time, as a missing or extra acknowledge in the ninth clock or as data driven when the line should be free. Address-decode faults show up in the acknowledge of the very first byte after START.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ID,
      ST_ID_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_RDAT,
      ST_RACK,
      ST_HOLD
   } cb_state_e;

   localparam int unsigned CB_BYTE_W = 8;
endpackage

// File: rtl/cfgbus_line_sync.sv
module cfgbus_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgbus_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
   assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgbus_id_sel.sv
module cfgbus_id_sel #(
   parameter int unsigned STRAP_W = 3,
   parameter logic [7:0]  BASE_ID = 8'hC0,
   parameter int unsigned STEP    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               multi_i,
   output logic [6:0]         dev_addr_o
);
   if (STRAP_W < 1 || STRAP_W > 4) begin : g_bad_strap
      $error("cfgbus_id_sel: STRAP_W must be 1..4");
   end
   if (STEP % 2 != 0) begin : g_bad_step
      $error("cfgbus_id_sel: STEP must be even to keep the direction bit free");
   end

   logic [STRAP_W-1:0] strap_q;
   logic               multi_q;
   logic               locked;
   logic [7:0]         full_id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q <= '0;
         multi_q <= 1'b0;
         locked  <= 1'b0;
      end else if (!locked) begin
         strap_q <= strap_i;
         multi_q <= multi_i;
         locked  <= 1'b1;
      end
   end

   assign full_id    = multi_q ? 8'(int'(BASE_ID) + int'(STEP) * int'(strap_q)) : BASE_ID;
   assign dev_addr_o = full_id[7:1];

   // R4: once captured, the answering address never moves
   a_r4_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(dev_addr_o));
endmodule

// File: rtl/cfgbus_regfile.sv
module cfgbus_regfile #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
   import cfgbus_pkg::*;
#(
   parameter int unsigned AW          = 8,
   parameter int unsigned STRAP_W     = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  BASE_ID     = 8'hC0,
   parameter int unsigned ID_STEP     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               multi_id_i
);
   if (AW < 1 || AW > CB_BYTE_W) begin : g_bad_aw
      $error("cfgbus_slave: AW must be 1..8");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
   logic [6:0] dev_addr;

   cb_state_e      state;
   logic [3:0]     bit_cnt;
   logic [7:0]     shreg;
   logic [AW-1:0]  ptr;
   logic           is_read, master_ack, sda_oe;
   logic           wr_en;
   logic [7:0]     rd_data;
   logic           byte_done;

   cfgbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop));

   cfgbus_id_sel #(.STRAP_W(STRAP_W), .BASE_ID(BASE_ID), .STEP(ID_STEP)) u_id (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .multi_i(multi_id_i),
      .dev_addr_o(dev_addr));

   cfgbus_regfile #(.AW(AW), .DW(CB_BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(shreg),
      .raddr(ptr), .rdata(rd_data));

   assign byte_done = scl_fall && (bit_cnt == 4'd8);
   assign wr_en     = (state == ST_WDAT) && byte_done && !bus_start && !bus_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         ptr        <= '0;
         is_read    <= 1'b0;
         master_ack <= 1'b0;
         sda_oe     <= 1'b0;
      end else if (bus_start) begin
         state   <= ST_ID;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
      end else if (bus_stop) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_ID, ST_SUB, ST_WDAT: begin
               if (scl_rise && bit_cnt < 4'd8) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_done) begin
                  bit_cnt <= '0;
                  if (state == ST_ID) begin
                     if (shreg[7:1] == dev_addr) begin
                        is_read <= shreg[0];
                        sda_oe  <= 1'b1;
                        state   <= ST_ID_ACK;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end else if (state == ST_SUB) begin
                     ptr    <= shreg[AW-1:0];
                     sda_oe <= 1'b1;
                     state  <= ST_SUB_ACK;
                  end else begin
                     ptr    <= ptr + 1'b1;
                     sda_oe <= 1'b1;
                     state  <= ST_WDAT_ACK;
                  end
               end
            end
            ST_ID_ACK, ST_SUB_ACK, ST_WDAT_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (state == ST_ID_ACK && is_read) begin
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     state  <= ST_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= (state == ST_ID_ACK) ? ST_SUB : ST_WDAT;
                  end
               end
            end
            ST_RDAT: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (scl_fall) begin
                  if (bit_cnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr + 1'b1;
                     state  <= ST_RACK;
                  end else begin
                     shreg  <= {shreg[6:0], 1'b0};
                     sda_oe <= ~shreg[6];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  master_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (master_ack) begin
                     shreg   <= rd_data;
                     sda_oe  <= ~rd_data[7];
                     bit_cnt <= '0;
                     state   <= ST_RDAT;
                  end else begin
                     state <= ST_HOLD;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = sda_oe;

   // R10: the line is only pulled while the clock is low
   a_r10_pull_when_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !$past(scl_s));
   // R5: a non-addressed slave stays off the line
   a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |-> !sda_oe_o);
   // R1: framing start always restarts address reception
   a_r1_start_to_id: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (state == ST_ID));
   // R11: a stop never disturbs the pointer
   a_r11_stop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> $stable(ptr));
   // R7: every stored byte advances the pointer by one, with wrap
   a_r7_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == AW'($past(ptr) + 1'b1)));
   // R12: idle slave never drives
   a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe_o);
endmodule

// File: tb/cfgbus_slave_bench.sv
module cfgbus_slave_bench;
   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'd0;
   logic       multi = 1'b0;
   logic       sda_oe;
   logic       sda_line;

   int checks = 0;
   int fails  = 0;
   int viol   = 0;
   logic prev_oe = 1'b0;
   logic [7:0] wid = 8'hC0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   cfgbus_slave u_cfgbus_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .strap_i(strap), .multi_id_i(multi));

   // R10 monitor: the output enable must not move while the clock line is high
   always @(negedge clk) begin
      if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
      prev_oe = sda_oe;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic m_start();
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic m_stop();
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
   endtask

   task automatic m_bit(input logic b, output logic seen);
      sda_m = b; qw(); scl_m = 1'b1; qw(); seen = sda_line; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack_line);
      logic s;
      for (int i = 7; i >= 0; i--) m_bit(b[i], s);
      m_bit(1'b1, ack_line);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         m_bit(1'b1, s);
         d[i] = s;
      end
      m_bit(~give_ack, s);
   endtask

   task automatic set_ptr(input logic [7:0] a);
      logic k;
      m_start(); send_byte(wid, k); send_byte(a, k); m_stop();
   endtask

   task automatic wr1(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
      logic k0, k1, k2;
      m_start(); send_byte(wid, k0); send_byte(a, k1); send_byte(d, k2); m_stop();
      acks = {k0, k1, k2};
   endtask

   task automatic rd1(output logic [7:0] d);
      logic k;
      m_start(); send_byte(wid | 8'h01, k); recv_byte(1'b0, d); m_stop();
   endtask

   task automatic do_reset(input logic m, input logic [2:0] s);
      rst_n = 1'b0; multi = m; strap = s;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      multi = ~m; strap = ~s;   // R4: later pin changes must be ignored
   endtask

   localparam logic [15:0] VEC [5] = '{16'h005A, 16'h7FA5, 16'hFF3C, 16'h1001, 16'h80FE};

   initial begin
      logic [7:0] d;
      logic [2:0] acks;
      logic k;

      do_reset(1'b0, 3'd0);
      // R12: reset state
      chk("R12 oe after reset", sda_oe, 1'b0);
      rd1(d);
      chk("R12 reg0 after reset", d, 8'h00);

      // R2 R6 R8: table of single writes, each read back via a fresh pointer
      for (int i = 0; i < 5; i++) begin
         wr1(VEC[i][15:8], VEC[i][7:0], acks);
         chk("R6 write acks", acks, 3'b000);
         set_ptr(VEC[i][15:8]);
         rd1(d);
         chk("R8 readback", d, VEC[i][7:0]);
      end

      // R2: read address is acknowledged
      m_start(); send_byte(8'hC1, k); chk("R2 read id ack", k, 1'b0);
      recv_byte(1'b0, d); m_stop();

      // R7: multi-byte write across the wrap
      m_start(); send_byte(wid, k); send_byte(8'hFE, k);
      send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k); m_stop();
      set_ptr(8'hFE);
      m_start(); send_byte(8'hC1, k);
      recv_byte(1'b1, d); chk("R7 byte FE", d, 8'h11);
      recv_byte(1'b1, d); chk("R7 byte FF", d, 8'h22);
      recv_byte(1'b0, d); chk("R7 wrapped byte 00", d, 8'h33);
      // R9: after not-acknowledge the line stays free
      repeat (20) @(negedge clk);
      chk("R9 released after nack", sda_oe, 1'b0);
      m_stop();

      // R8 R9: pointer persists across read transfers
      m_start(); send_byte(wid, k); send_byte(8'h20, k);
      send_byte(8'hA1, k); send_byte(8'hA2, k); send_byte(8'hA3, k); m_stop();
      set_ptr(8'h20);
      m_start(); send_byte(8'hC1, k);
      recv_byte(1'b1, d); chk("R9 first", d, 8'hA1);
      recv_byte(1'b0, d); chk("R9 second", d, 8'hA2);
      m_stop();
      rd1(d); chk("R8 pointer kept", d, 8'hA3);

      // R5: foreign address, then a START straight from the ignored state (R1)
      m_start(); send_byte(8'hC4, k); chk("R5 mismatch nack", k, 1'b1);
      send_byte(8'h30, k); chk("R5 no ack on sub", k, 1'b1);
      send_byte(8'h99, k); chk("R5 no ack on data", k, 1'b1);
      m_start(); send_byte(wid, k); chk("R1 start from ignore", k, 1'b0);
      send_byte(8'h30, k); m_stop();
      rd1(d); chk("R5 register untouched", d, 8'h00);

      // R11: stop in the middle of a sub-address byte
      wr1(8'h40, 8'h77, acks);
      set_ptr(8'h40);
      m_start(); send_byte(wid, k);
      m_bit(1'b0, k); m_bit(1'b1, k); m_bit(1'b0, k);
      m_stop();
      rd1(d); chk("R11 pointer after abort", d, 8'h77);

      chk("R10 no change with clock high", viol, 0);

      // R3 R4: multi-address mode, strap 5
      do_reset(1'b1, 3'd5);
      wid = 8'hD4;
      m_start(); send_byte(8'hC0, k); chk("R3 base addr refused", k, 1'b1); m_stop();
      m_start(); send_byte(8'hC8, k); chk("R4 new strap ignored", k, 1'b1); m_stop();
      wr1(8'h05, 8'h66, acks);
      chk("R3 strap addr acks", acks, 3'b000);
      set_ptr(8'h05);
      m_start(); send_byte(8'hD5, k); chk("R3 read addr ack", k, 1'b0);
      recv_byte(1'b0, d); m_stop();
      chk("R3 readback", d, 8'h66);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule